// File: doc/BRIEF.md
# Postfix Stack Arithmetic Engine

This block evaluates postfix (reverse Polish) expressions with a small register stack that works as a last-in first-out store. A host sends one command per clock cycle over a valid/ready port. A command either pushes an immediate value, combines the two uppermost entries with an addition or a subtraction, removes the top entry, or reads the top entry. Arithmetic commands never name their operands. They always take them from the top of the stack and leave a single result in their place.

Popped and read values come back on a response port one cycle after the command. The current top entry and the number of stored entries are always visible on outputs. An illegal command sets a sticky error flag and leaves the stack as it was. Illegal commands are stack underflow, stack overflow, and arithmetic with fewer than two entries. Only reset clears the flag.

Top module: `postfix_stack_engine`

## Requirements
- R1: While reset is active, and after it is released, `depth` is 0, `top_value` is 0, `err_flag` is 0 and `rsp_valid` is 0.
- R2: An accepted command with `cmd_op` = 0 (push) on a stack below `DEPTH` entries places `cmd_data` on top and raises `depth` by one. Both are visible after the accepting clock edge.
- R3: An accepted `cmd_op` = 1 (add) with at least two entries replaces them with their sum modulo 2^`DATA_W` and lowers `depth` by one.
- R4: An accepted `cmd_op` = 2 (subtract) with at least two entries replaces them with (entry below top) minus (top), modulo 2^`DATA_W`, and lowers `depth` by one.
- R5: An accepted `cmd_op` = 3 (pop) on a non-empty stack removes the top entry. In the next cycle `rsp_valid` is high for one cycle and `rsp_data` holds the removed value.
- R6: An accepted `cmd_op` = 4 (read top) on a non-empty stack gives a one-cycle response carrying the top value and leaves `depth` and `top_value` unchanged.
- R7: A push on a full stack, an add or subtract with fewer than two entries, and a pop or read-top on an empty stack each set `err_flag`, produce no response, and leave `depth` and `top_value` unchanged.
- R8: `err_flag` stays high through all later commands until reset, and legal commands still execute while it is high.
- R9: Command codes 5, 6 and 7, and any cycle with `cmd_valid` low, change neither the stack, `err_flag` nor the response.
- R10: `cmd_ready` is high whenever reset is not active, so commands may be issued on consecutive cycles.
- R11: The postfix stream 2 3 + 2 − followed by a read-top returns 3 with `depth` equal to 1.
- R12: `top_value` is 0 whenever `depth` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine accepts a command this cycle |
| cmd_op | input | 3 | Command code: 0 push, 1 add, 2 subtract, 3 pop, 4 read top |
| cmd_data | input | DATA_W | Immediate value for push |
| rsp_valid | output | 1 | One-cycle pulse carrying a pop or read-top result |
| rsp_data | output | DATA_W | Popped or read value |
| top_value | output | DATA_W | Current top entry, 0 when empty |
| depth | output | $clog2(DEPTH+1) | Number of stored entries |
| err_flag | output | 1 | Sticky error indication |

## Verification
The bench builds the engine with `DEPTH` = 4 and `DATA_W` = 8. With four entries, the full-stack push refusal and the boundary between three and four entries are reached within a handful of random commands. Eight-bit words make sums and differences wrap often, so the modulo behaviour of both arithmetic commands and the operand order of subtraction are exercised without chosen values. Periodic resets let the sticky flag be observed both set and clear many times in one run.

// File: rtl/postfix_pkg.sv
package postfix_pkg;
  localparam logic [2:0] OPC_PUSH = 3'd0;
  localparam logic [2:0] OPC_ADD  = 3'd1;
  localparam logic [2:0] OPC_SUB  = 3'd2;
  localparam logic [2:0] OPC_POP  = 3'd3;
  localparam logic [2:0] OPC_PEEK = 3'd4;

  typedef enum logic [1:0] {
    WSRC_NONE = 2'd0,
    WSRC_IMM  = 2'd1,
    WSRC_ALU  = 2'd2
  } wsrc_e;
endpackage

// File: rtl/postfix_ctrl.sv
module postfix_ctrl
  import postfix_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1),
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             fire,
  input  logic [2:0]       op,
  input  logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] count_nxt,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output wsrc_e            wr_src,
  output logic             alu_sub,
  output logic             rsp_set,
  output logic             err_set
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [CNT_W-1:0] below_two;
  logic             empty;
  logic             has_two;

  assign below_two = count - CNT_W'(2);
  assign empty     = (count == '0);
  assign has_two   = (count >= CNT_W'(2));

  always_comb begin
    count_nxt = count;
    wr_en     = 1'b0;
    wr_idx    = '0;
    wr_src    = WSRC_NONE;
    alu_sub   = 1'b0;
    rsp_set   = 1'b0;
    err_set   = 1'b0;
    if (fire) begin
      case (op)
        OPC_PUSH: begin
          if (count == FULL) begin
            err_set = 1'b1;
          end else begin
            wr_en     = 1'b1;
            wr_idx    = count[IDX_W-1:0];
            wr_src    = WSRC_IMM;
            count_nxt = count + CNT_W'(1);
          end
        end
        OPC_ADD, OPC_SUB: begin
          if (!has_two) begin
            err_set = 1'b1;
          end else begin
            wr_en     = 1'b1;
            wr_idx    = below_two[IDX_W-1:0];
            wr_src    = WSRC_ALU;
            alu_sub   = (op == OPC_SUB);
            count_nxt = count - CNT_W'(1);
          end
        end
        OPC_POP: begin
          if (empty) begin
            err_set = 1'b1;
          end else begin
            rsp_set   = 1'b1;
            count_nxt = count - CNT_W'(1);
          end
        end
        OPC_PEEK: begin
          if (empty) err_set = 1'b1;
          else       rsp_set = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/postfix_lifo.sv
module postfix_lifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = $clog2(DEPTH + 1),
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CNT_W-1:0]  count,
  output logic [DATA_W-1:0] top,
  output logic [DATA_W-1:0] nxt
);
  logic [DATA_W-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_en;
    assign slot_en = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q[g] <= '0;
      else if (slot_en) slot_q[g] <= wr_data;
    end
  end

  always_comb begin
    top = '0;
    nxt = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (count == CNT_W'(i + 1)) top = slot_q[i];
      if (count == CNT_W'(i + 2)) nxt = slot_q[i];
    end
  end
endmodule

// File: rtl/postfix_alu.sv
module postfix_alu #(
  parameter int DATA_W = 16
) (
  input  logic              sub,
  input  logic [DATA_W-1:0] lower,
  input  logic [DATA_W-1:0] upper,
  output logic [DATA_W-1:0] result
);
  always_comb begin
    if (sub) result = lower - upper;
    else     result = lower + upper;
  end
endmodule

// File: rtl/postfix_stack_engine.sv
module postfix_stack_engine
  import postfix_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [DATA_W-1:0] top_value,
  output logic [CNT_W-1:0]  depth,
  output logic              err_flag
);
  // reset synchronizer: assert at once, release on a clock edge
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic              fire;
  logic [CNT_W-1:0]  count_q, count_d;
  logic              err_q, err_d;
  logic              rspv_q, rspv_d;
  logic [DATA_W-1:0] rspd_q, rspd_d;
  logic              wr_en, alu_sub, rsp_set, err_set;
  logic [IDX_W-1:0]  wr_idx;
  wsrc_e             wr_src;
  logic [DATA_W-1:0] top_w, nxt_w, alu_w, wr_data;

  assign cmd_ready = rst_sync_n;
  assign fire      = cmd_valid && cmd_ready;

  postfix_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_ctrl (
    .fire      (fire),
    .op        (cmd_op),
    .count     (count_q),
    .count_nxt (count_d),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_src    (wr_src),
    .alu_sub   (alu_sub),
    .rsp_set   (rsp_set),
    .err_set   (err_set)
  );

  postfix_alu #(.DATA_W(DATA_W)) u_alu (
    .sub    (alu_sub),
    .lower  (nxt_w),
    .upper  (top_w),
    .result (alu_w)
  );

  assign wr_data = (wr_src == WSRC_ALU) ? alu_w : cmd_data;

  postfix_lifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_lifo (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .count   (count_q),
    .top     (top_w),
    .nxt     (nxt_w)
  );

  always_comb begin
    err_d  = err_q | err_set;
    rspv_d = rsp_set;
    rspd_d = rsp_set ? top_w : rspd_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      count_q <= '0;
      err_q   <= 1'b0;
      rspv_q  <= 1'b0;
      rspd_q  <= '0;
    end else begin
      count_q <= count_d;
      err_q   <= err_d;
      rspv_q  <= rspv_d;
      if (rsp_set) rspd_q <= rspd_d;
    end
  end

  assign rsp_valid = rspv_q;
  assign rsp_data  = rspd_q;
  assign top_value = top_w;
  assign depth     = count_q;
  assign err_flag  = err_q;
endmodule

// File: rtl/postfix_stack_engine_chk.sv
module postfix_stack_engine_chk #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              cmd_valid,
  input logic [2:0]        cmd_op,
  input logic [DATA_W-1:0] cmd_data,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] top_value,
  input logic [CNT_W-1:0]  depth,
  input logic              err_flag
);
  a_r2_push_lands_on_top: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cmd_valid && cmd_op == 3'd0 && depth < CNT_W'(DEPTH))
      |=> (depth == $past(depth) + CNT_W'(1)) && (top_value == $past(cmd_data)));

  a_r3_add_shrinks: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cmd_valid && cmd_op == 3'd1 && depth >= CNT_W'(2))
      |=> depth == $past(depth) - CNT_W'(1));

  a_r5_pop_answers: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cmd_valid && cmd_op == 3'd3 && depth != '0) |=> rsp_valid);

  a_r7_underflow_refused: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cmd_valid && cmd_op == 3'd3 && depth == '0)
      |=> $stable(depth) && err_flag && !rsp_valid);

  a_r8_error_sticky: assert property (@(posedge clk) disable iff (!rst_q_n)
    err_flag |=> err_flag);

  a_r9_unused_code_idle: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cmd_valid && cmd_op >= 3'd5) |=> $stable(depth) && $stable(top_value) && !rsp_valid);

  a_r12_empty_top_zero: assert property (@(posedge clk) disable iff (!rst_q_n)
    (depth == '0) |-> (top_value == '0));
endmodule

bind postfix_stack_engine postfix_stack_engine_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_q_n   (rst_sync_n),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .cmd_data  (cmd_data),
  .rsp_valid (rsp_valid),
  .top_value (top_value),
  .depth     (depth),
  .err_flag  (err_flag)
);

// File: tb/postfix_stack_engine_test.sv
`timescale 1ns/1ps
module postfix_stack_engine_test;
  localparam int DW = 8;
  localparam int DP = 4;
  localparam int CW = $clog2(DP + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [2:0]    cmd_op = 3'd0;
  logic [DW-1:0] cmd_data = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;
  logic [DW-1:0] top_value;
  logic [CW-1:0] depth;
  logic          err_flag;

  always #10 clk = ~clk;

  postfix_stack_engine #(.DATA_W(DW), .DEPTH(DP)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_data(cmd_data), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .top_value(top_value), .depth(depth), .err_flag(err_flag)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [DW-1:0] stk [DP];
  int            e_cnt;
  logic          e_err, e_rv;
  logic [DW-1:0] e_rd;
  string         cur_tag = "R1";

  function automatic logic [DW-1:0] e_top();
    return (e_cnt == 0) ? '0 : stk[e_cnt-1];
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "depth", int'(depth), e_cnt);
    chk(tag, "top_value", int'(top_value), int'(e_top()));
    chk(tag, "err_flag", int'(err_flag), int'(e_err));
    chk(tag, "rsp_valid", int'(rsp_valid), int'(e_rv));
    if (e_rv) chk(tag, "rsp_data", int'(rsp_data), int'(e_rd));
    if (rst_n) chk("R10", "cmd_ready", int'(cmd_ready), 1);
  endtask

  task automatic model(input logic v, input logic [2:0] op, input logic [DW-1:0] d);
    e_rv = 1'b0;
    if (v) begin
      case (op)
        3'd0: if (e_cnt == DP) e_err = 1'b1; else begin stk[e_cnt] = d; e_cnt++; end
        3'd1, 3'd2: begin
          if (e_cnt < 2) e_err = 1'b1;
          else begin
            stk[e_cnt-2] = (op == 3'd1) ? stk[e_cnt-2] + stk[e_cnt-1]
                                        : stk[e_cnt-2] - stk[e_cnt-1];
            e_cnt--;
          end
        end
        3'd3: if (e_cnt == 0) e_err = 1'b1; else begin e_rv = 1'b1; e_rd = stk[e_cnt-1]; e_cnt--; end
        3'd4: if (e_cnt == 0) e_err = 1'b1; else begin e_rv = 1'b1; e_rd = stk[e_cnt-1]; end
        default: ;
      endcase
    end
  endtask

  task automatic step(input logic v, input logic [2:0] op, input logic [DW-1:0] d, input string tag);
    @(negedge clk);
    check_all(cur_tag);
    cmd_valid = v;
    cmd_op    = op;
    cmd_data  = d;
    model(v, op, d);
    cur_tag = tag;
  endtask

  task automatic flush();
    @(negedge clk);
    check_all(cur_tag);
    cmd_valid = 1'b0;
    model(1'b0, 3'd0, '0);
    cur_tag = "R9";
  endtask

  task automatic do_reset();
    @(negedge clk);
    cmd_valid = 1'b0;
    rst_n = 1'b0;
    e_cnt = 0; e_err = 1'b0; e_rv = 1'b0; e_rd = '0;
    repeat (2) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R1");
    cur_tag = "R1";
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    do_reset();

    // R11: 2 3 + 2 - then read top
    step(1, 3'd0, 8'd2, "R2");
    step(1, 3'd0, 8'd3, "R2");
    step(1, 3'd1, 8'd0, "R3");
    step(1, 3'd0, 8'd2, "R2");
    step(1, 3'd2, 8'd0, "R4");
    step(1, 3'd4, 8'd0, "R11");
    flush();
    chk("R11", "depth", int'(depth), 1);

    // R4 operand order and wrap: 3 5 - = 254
    step(1, 3'd0, 8'd3, "R2");
    step(1, 3'd0, 8'd5, "R2");
    step(1, 3'd2, 8'd0, "R4");
    step(1, 3'd3, 8'd0, "R5");
    step(1, 3'd3, 8'd0, "R5");
    step(1, 3'd5, 8'd9, "R9");
    step(0, 3'd0, 8'd7, "R9");
    step(1, 3'd7, 8'd1, "R12");
    flush();

    // R7: underflow cases, then overflow
    step(1, 3'd3, 8'd0, "R7");
    step(1, 3'd4, 8'd0, "R7");
    step(1, 3'd0, 8'd9, "R8");
    step(1, 3'd1, 8'd0, "R7");
    for (int i = 0; i < DP - 1; i++) step(1, 3'd0, DW'(i + 20), "R8");
    step(1, 3'd0, 8'd99, "R7");
    step(1, 3'd6, 8'd0, "R9");
    step(1, 3'd2, 8'd0, "R8");
    flush();

    do_reset();
    step(1, 3'd0, 8'd200, "R2");
    step(1, 3'd0, 8'd100, "R2");
    step(1, 3'd1, 8'd0, "R3");
    step(1, 3'd4, 8'd0, "R6");
    step(1, 3'd3, 8'd0, "R5");
    flush();

    // constrained random with periodic resets
    for (int n = 0; n < 800; n++) begin
      int r;
      logic [2:0] op;
      if (n % 60 == 59) do_reset();
      r = int'($urandom % 16);
      if (r < 6)       op = 3'd0;
      else if (r < 8)  op = 3'd1;
      else if (r < 10) op = 3'd2;
      else if (r < 12) op = 3'd3;
      else if (r < 14) op = 3'd4;
      else             op = 3'($urandom % 3 + 5);
      case (op)
        3'd0: step(r != 5, op, DW'($urandom), "R2");
        3'd1: step(1'b1, op, '0, "R3");
        3'd2: step(1'b1, op, '0, "R4");
        3'd3: step(1'b1, op, '0, "R5");
        3'd4: step(1'b1, op, '0, "R6");
        default: step(1'b1, op, DW'($urandom), "R9");
      endcase
    end
    flush();

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule